// File: doc/BRIEF.md
# Interrupt Line Trigger Conditioner

This block conditions a single raw interrupt line from a peripheral into a pending request for the interrupt controller core. One copy is placed on each line. A 3-bit trigger-type input picks how the line is read. Code 1 selects latched edge capture. It suits sources that clear themselves, such as timers, DMA engines and frame-timing strobes. Code 5 selects unlatched level sampling. It suits sources that hold their line high until their own status register is cleared. Every other code keeps the request low.

The core drives two strobes. `claim` marks that this line's interrupt has been taken into service. `ack` marks that the handler has finished. The raw line is registered once and then compared with its value one clock earlier to find rising edges. A small state machine holds the mode's state. In ST_IDLE nothing is latched and nothing is in service. In ST_PEND an edge has been captured and is waiting for a claim (edge mode only). In ST_SERVICE the request has been claimed and is waiting for an acknowledge.

The transitions are:
- ST_IDLE→ST_PEND on a detected rising edge in edge mode.
- ST_PEND→ST_SERVICE on claim.
- ST_IDLE→ST_SERVICE on claim while the sampled line is high in level mode.
- ST_SERVICE→ST_IDLE on ack.
- Any state→ST_IDLE when the decoded mode differs from the previous cycle's mode or is unsupported.

Top module: `trig_conditioner`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pending` is 0.
- R2: With `trig_type` = 1 (edge mode), `raw_line` low in one cycle and high in the next sets `pending` two clock edges after the high value is first set up. `pending` then stays high, even if the line falls, until it is claimed.
- R3: In edge mode, `claim` while `pending` is high clears `pending` at the next edge. `claim` while `pending` is low has no effect.
- R4: In edge mode, a rising edge that arrives after the claim and before the following `ack` is dropped. After the `ack`, only a fresh rising edge sets `pending` again.
- R5: With `trig_type` = 5 (level mode) and nothing in service, `pending` equals `raw_line` as sampled at the previous clock edge. Nothing is stored, so a one-cycle pulse gives exactly one cycle of `pending`.
- R6: In level mode, `claim` while `pending` is high forces `pending` low until `ack`. From the cycle after `ack`, `pending` follows the sampled line again. It is high only if the line is still high.
- R7: For any `trig_type` other than 1 or 5, `pending` is 0.
- R8: A change of the decoded mode between two cycles returns the state machine to ST_IDLE. Any captured or in-service state is dropped: after switching away from edge mode and back, with the line held steady, `pending` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_line | input | 1 | Raw interrupt line from the peripheral, already synchronous to `clk` |
| trig_type | input | 3 | Trigger type: 1 = edge, 5 = level, others = off |
| claim | input | 1 | Core has taken this line's interrupt into service |
| ack | input | 1 | Core has finished servicing this line |
| pending | output | 1 | Conditioned interrupt request |

## Verification
The hardest case to reach is a second rising edge that lands inside the window between claim and acknowledge in edge mode. To produce it, the line must fall and rise again while the core holds the interrupt in service. A directed sequence builds that window on purpose. After it, a sweep over all eight trigger codes drives pseudo-random line, claim and acknowledge patterns against a cycle-level model. The model also changes the code mid-stream, so captured and in-service states are dropped at the boundaries between modes.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PEND    = 2'd1,
        ST_SERVICE = 2'd2
    } trig_state_e;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_EDGE  = 2'd1,
        MODE_LEVEL = 2'd2
    } trig_mode_e;
endpackage

// File: rtl/trig_sample.sv
module trig_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_line,
    output logic line_q,
    output logic rise
);
    logic line_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            line_prev <= 1'b0;
        end else begin
            line_q    <= raw_line;
            line_prev <= line_q;
        end
    end

    assign rise = line_q & ~line_prev;
endmodule

// File: rtl/trig_decode.sv
module trig_decode
    import trig_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter logic [TYPE_W-1:0] EDGE_CODE  = 1,
    parameter logic [TYPE_W-1:0] LEVEL_CODE = 5
) (
    input  logic [TYPE_W-1:0] trig_type,
    output trig_mode_e        mode
);
    always_comb begin
        if (trig_type == EDGE_CODE)
            mode = MODE_EDGE;
        else if (trig_type == LEVEL_CODE)
            mode = MODE_LEVEL;
        else
            mode = MODE_OFF;
    end
endmodule

// File: rtl/trig_fsm.sv
module trig_fsm
    import trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  trig_mode_e  mode,
    input  logic        line_q,
    input  logic        rise,
    input  logic        claim,
    input  logic        ack,
    output trig_state_e state,
    output logic        pending
);
    trig_state_e state_nx;
    trig_mode_e  mode_q;
    logic        retype;

    assign retype = (mode != mode_q) || (mode == MODE_OFF);

    always_comb begin
        state_nx = state;
        if (retype) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mode == MODE_EDGE && rise)
                        state_nx = ST_PEND;
                    else if (mode == MODE_LEVEL && line_q && claim)
                        state_nx = ST_SERVICE;
                end
                ST_PEND: begin
                    if (claim)
                        state_nx = ST_SERVICE;
                end
                ST_SERVICE: begin
                    if (ack)
                        state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mode_q <= MODE_OFF;
        end else begin
            state  <= state_nx;
            mode_q <= mode;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_EDGE:  pending = (state == ST_PEND);
            MODE_LEVEL: pending = (state != ST_SERVICE) && line_q;
            default:    pending = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_conditioner.sv
module trig_conditioner
    import trig_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter logic [TYPE_W-1:0] EDGE_CODE  = 1,
    parameter logic [TYPE_W-1:0] LEVEL_CODE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_line,
    input  logic [TYPE_W-1:0] trig_type,
    input  logic              claim,
    input  logic              ack,
    output logic              pending
);
    logic        line_q;
    logic        rise;
    trig_mode_e  mode;
    trig_state_e state;

    trig_sample u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_line (raw_line),
        .line_q   (line_q),
        .rise     (rise)
    );

    trig_decode #(
        .TYPE_W     (TYPE_W),
        .EDGE_CODE  (EDGE_CODE),
        .LEVEL_CODE (LEVEL_CODE)
    ) u_decode (
        .trig_type (trig_type),
        .mode      (mode)
    );

    trig_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .line_q  (line_q),
        .rise    (rise),
        .claim   (claim),
        .ack     (ack),
        .state   (state),
        .pending (pending)
    );
endmodule

// File: rtl/trig_conditioner_chk.sv
module trig_conditioner_chk
    import trig_pkg::*;
#(
    parameter int TYPE_W = 3,
    parameter logic [TYPE_W-1:0] EDGE_CODE  = 1,
    parameter logic [TYPE_W-1:0] LEVEL_CODE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              raw_line,
    input logic [TYPE_W-1:0] trig_type,
    input logic              claim,
    input logic              ack,
    input logic              pending,
    input trig_state_e       state,
    input logic              line_q
);
    logic [TYPE_W-1:0] type_d;
    logic              lq_d;
    logic              is_edge;
    logic              is_level;

    assign is_edge  = (trig_type == EDGE_CODE);
    assign is_level = (trig_type == LEVEL_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_d <= '0;
            lq_d   <= 1'b0;
        end else begin
            type_d <= trig_type;
            lq_d   <= line_q;
        end
    end

    a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_edge && !is_level) |-> !pending);

    a_r2_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && type_d == trig_type && state == ST_IDLE && line_q && !lq_d)
        |=> (pending || !is_edge));

    a_r3_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && pending && claim) |=> (!pending || !is_edge));

    a_r4_service_deaf: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && state == ST_SERVICE && !ack) |=> (!pending || !is_edge));

    a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level && state == ST_IDLE && !claim)
        |=> (!is_level || pending == $past(raw_line)));

    a_r6_level_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (is_level && pending && claim) |=> (!pending || !is_level));

    a_r8_retype_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (type_d != trig_type) |=> (state == ST_IDLE));
endmodule

bind trig_conditioner trig_conditioner_chk #(
    .TYPE_W     (TYPE_W),
    .EDGE_CODE  (EDGE_CODE),
    .LEVEL_CODE (LEVEL_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_line  (raw_line),
    .trig_type (trig_type),
    .claim     (claim),
    .ack       (ack),
    .pending   (pending),
    .state     (state),
    .line_q    (line_q)
);

// File: tb/trig_conditioner_test.sv
`timescale 1ns/1ps
module trig_conditioner_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw_line = 1'b0;
    logic [2:0] trig_type = 3'd1;
    logic       claim = 1'b0;
    logic       ack = 1'b0;
    logic       pending;

    int total = 0;
    int bad = 0;

    // reference model state (0 idle, 1 latched, 2 in service)
    logic       m_lq = 1'b0;
    logic       m_lqq = 1'b0;
    int         m_st = 0;
    int         m_mode_q = 0;

    always #2 clk = ~clk;

    trig_conditioner uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_line  (raw_line),
        .trig_type (trig_type),
        .claim     (claim),
        .ack       (ack),
        .pending   (pending)
    );

    function automatic int mode_of(logic [2:0] t);
        if (t == 3'd1) return 1;
        if (t == 3'd5) return 2;
        return 0;
    endfunction

    function automatic logic model_pending();
        int m = mode_of(trig_type);
        if (m == 1) return (m_st == 1);
        if (m == 2) return (m_st != 2) && m_lq;
        return 1'b0;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pending=%0b expected=%0b type=%0d t=%0t",
                     tag, act, exp, trig_type, $time);
        end
    endtask

    task automatic model_step();
        int m = mode_of(trig_type);
        int nx = m_st;
        logic rise = m_lq & ~m_lqq;
        if (!rst_n) begin
            m_st = 0; m_mode_q = 0; m_lq = 1'b0; m_lqq = 1'b0;
            return;
        end
        if (m != m_mode_q || m == 0) nx = 0;
        else if (m_st == 0) begin
            if (m == 1 && rise) nx = 1;
            else if (m == 2 && m_lq && claim) nx = 2;
        end else if (m_st == 1) begin
            if (claim) nx = 2;
        end else if (ack) nx = 0;
        m_st = nx;
        m_mode_q = m;
        m_lqq = m_lq;
        m_lq = raw_line;
    endtask

    // one clock: model follows the edge, compare at the falling edge
    task automatic cycle(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, pending, model_pending());
    endtask

    task automatic drive(logic r, logic c, logic a);
        raw_line = r; claim = c; ack = a;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        @(negedge clk);
        cycle("R1"); cycle("R1");
        check("R1", pending, 1'b0);
        rst_n = 1'b1;
        cycle("R1");
        check("R1", pending, 1'b0);

        // R2: edge capture latency and latch
        drive(1, 0, 0); cycle("R2");
        check("R2", pending, 1'b0);
        cycle("R2");
        check("R2", pending, 1'b1);
        drive(0, 0, 0); cycle("R2"); cycle("R2");
        check("R2", pending, 1'b1);

        // R3: claim clears; stray claim ignored
        drive(0, 1, 0); cycle("R3");
        check("R3", pending, 1'b0);
        drive(0, 0, 1); cycle("R3");
        drive(0, 1, 0); cycle("R3"); cycle("R3");
        check("R3", pending, 1'b0);

        // R4: edge during service is dropped
        drive(1, 0, 0); cycle("R4"); cycle("R4");
        check("R4", pending, 1'b1);
        drive(1, 1, 0); cycle("R4");
        drive(0, 0, 0); cycle("R4");
        drive(1, 0, 0); cycle("R4"); cycle("R4"); cycle("R4");
        check("R4", pending, 1'b0);
        drive(1, 0, 1); cycle("R4");
        drive(1, 0, 0); cycle("R4"); cycle("R4");
        check("R4", pending, 1'b0);
        drive(0, 0, 0); cycle("R4");
        drive(1, 0, 0); cycle("R4"); cycle("R4");
        check("R4", pending, 1'b1);

        // R8: leave edge mode and come back with line held high
        trig_type = 3'd3; cycle("R8");
        check("R8", pending, 1'b0);
        trig_type = 3'd1; cycle("R8"); cycle("R8"); cycle("R8");
        check("R8", pending, 1'b0);

        // R5: level sampling, single-cycle pulse
        trig_type = 3'd5; drive(0, 0, 0); cycle("R5"); cycle("R5");
        check("R5", pending, 1'b0);
        drive(1, 0, 0); cycle("R5");
        check("R5", pending, 1'b1);
        drive(0, 0, 0); cycle("R5");
        check("R5", pending, 1'b0);

        // R6: mask between claim and ack
        drive(1, 0, 0); cycle("R6");
        check("R6", pending, 1'b1);
        drive(1, 1, 0); cycle("R6");
        check("R6", pending, 1'b0);
        drive(1, 0, 0); cycle("R6"); cycle("R6");
        check("R6", pending, 1'b0);
        drive(1, 0, 1); cycle("R6");
        check("R6", pending, 1'b1);
        drive(1, 1, 0); cycle("R6");
        drive(0, 0, 1); cycle("R6");
        check("R6", pending, 1'b0);
        drive(0, 0, 0); cycle("R6");
        check("R6", pending, 1'b0);

        // R7: unsupported code with busy line
        trig_type = 3'd7; drive(1, 0, 0); cycle("R7");
        drive(0, 0, 0); cycle("R7");
        drive(1, 0, 0); cycle("R7");
        check("R7", pending, 1'b0);

        // sweep all codes with pseudo-random traffic
        lfsr = 16'hACE1;
        for (int t = 0; t < 8; t++) begin
            trig_type = 3'(t);
            for (int k = 0; k < 400; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                drive(lfsr[0] ^ lfsr[5], lfsr[3] & lfsr[7], lfsr[9] & lfsr[2]);
                if (mode_of(trig_type) == 1) cycle("R2");
                else if (mode_of(trig_type) == 2) cycle("R5");
                else cycle("R7");
            end
        end
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[4:0] == 5'd0) trig_type = lfsr[8] ? 3'd1 : (lfsr[6] ? 3'd5 : 3'd2);
            drive(lfsr[1], lfsr[11] & lfsr[4], lfsr[14] & lfsr[6]);
            cycle("R8");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule